// File: doc/BRIEF.md
# Timer Event Capture Unit

This block takes a snapshot of a free-running counter when an external event occurs. The event can come from a dedicated input pin or from the digital output of an analog comparator. Either source is synchronized to the clock, and can then pass through an optional glitch filter. After that, an edge detector watches for the chosen polarity. When an edge is accepted, the counter value from that clock edge is stored in a capture register, and a capture flag is raised. The flag drives an interrupt request only while the interrupt is enabled.

Software reads the capture register one byte at a time over a narrow bus. Reading byte index 0 returns the low byte. The same read also copies all upper bytes into a holding register, and later reads of the higher indices return that held copy. A multi-byte value therefore stays coherent even if a new capture lands between the byte reads. Changing the source or the polarity can produce a spurious capture. The flag can be cleared by writing one to it or by an interrupt acknowledge, so software clears it after reconfiguring.

The counter itself is outside this block. Counter width, bus width, synchronizer depth and filter length are parameters.

Top module: `tcap_unit`

## Requirements
- R1: On an accepted event, the capture register is loaded with the full `cnt_val` value present at the capture clock edge. Reading with `rd_en`=1 and `rd_idx`=0 returns capture bits [7:0] on `rd_data`.
- R2: `cfg_src_cmp`=0 selects `trig_pin` as the event source and `cfg_src_cmp`=1 selects `trig_cmp`. Transitions on the unselected input never cause a capture.
- R3: `cfg_rise`=1 captures on a 0-to-1 transition of the filtered source level, and `cfg_rise`=0 captures on a 1-to-0 transition. The opposite transition causes no capture.
- R4: With the filter off, a source change first sampled at clock edge k is captured at edge k+2: two synchronizer stages, then the capture register. `cnt_val` is sampled at edge k+2.
- R5: With `cfg_filt_en`=1, a new level is accepted only after 4 consecutive synchronized samples agree on it. Pulses lasting 3 cycles or fewer are ignored, and a valid edge is captured at edge k+6, 4 cycles later than without the filter.
- R6: A capture sets `cap_flag` on the capture edge. When a capture and a clear request fall on the same edge, the set wins.
- R7: A clock edge with `flag_wr1`=1 or `irq_ack`=1 and no capture clears `cap_flag`.
- R8: `irq` equals `cap_flag` AND `irq_en`, as a combinational output.
- R9: A read of index 0 latches capture bits [15:8] into a holding register on that clock edge. A later read with `rd_idx`=1 returns the held byte, even if a new capture has happened in between. With `rd_en`=0, `rd_data` is 0.
- R10: After reset, `cap_flag`, `irq`, the capture register, the holding register and all level-tracking state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Free-running counter value |
| trig_pin | input | 1 | Asynchronous event pin |
| trig_cmp | input | 1 | Comparator output used as event source |
| cfg_src_cmp | input | 1 | 1 selects comparator, 0 selects pin |
| cfg_rise | input | 1 | 1 rising edge, 0 falling edge |
| cfg_filt_en | input | 1 | Enables glitch filter |
| irq_en | input | 1 | Interrupt enable |
| flag_wr1 | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| rd_en | input | 1 | Byte read strobe |
| rd_idx | input | 1 | Byte index of the read |
| rd_data | output | 8 | Read data byte |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter, an 8-bit bus, two synchronizer stages and a four-sample filter. With these values, the exact latencies of two and six cycles can be checked against counter values the bench computes by hand. Three-cycle glitches fall just below the filter threshold and are rejected. Two byte indices are enough to show the low-byte read latching the upper byte across a new capture, and the bench makes the counter jump so the two captures differ in their high bytes.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_CMP = 1'b1
   } tcap_src_e;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } tcap_edge_e;

   typedef struct packed {
      tcap_src_e  src;
      tcap_edge_e pol;
      logic       filt;
   } tcap_cfg_t;

   function automatic int idx_width(input int nbytes);
      return (nbytes > 1) ? $clog2(nbytes) : 1;
   endfunction
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tcap_filter.sv
module tcap_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic lvl
);
   generate
      if (FILT_LEN < 2) begin : g_none
         logic unused_en;
         assign unused_en = en ^ clk ^ rst_n;
         assign lvl = din;
      end else begin : g_vote
         logic [FILT_LEN-2:0] hist;
         logic [FILT_LEN-1:0] win;
         logic                acc;
         logic                agree_hi;
         logic                agree_lo;

         assign win      = {hist, din};
         assign agree_hi = &win;
         assign agree_lo = ~(|win);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist <= '0;
               acc  <= 1'b0;
            end else begin
               hist <= win[FILT_LEN-2:0];
               if (!en)           acc <= din;
               else if (agree_hi) acc <= 1'b1;
               else if (agree_lo) acc <= 1'b0;
            end
         end

         assign lvl = en ? acc : din;
      end
   endgenerate
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge
   import tcap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  tcap_edge_e pol,
   output logic       evt
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   always_comb begin
      unique case (pol)
         EDGE_RISE: evt = lvl & ~prev;
         EDGE_FALL: evt = ~lvl & prev;
         default:   evt = 1'b0;
      endcase
   end
endmodule

// File: rtl/tcap_store.sv
module tcap_store #(
   parameter int CW   = 16,
   parameter int BW   = 8,
   parameter int IDXW = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt,
   input  logic [CW-1:0]   cnt,
   input  logic            rd_en,
   input  logic [IDXW-1:0] rd_idx,
   output logic [BW-1:0]   rd_data,
   output logic [CW-1:0]   cap_q,
   output logic [CW-BW-1:0] tmp_q
);
   localparam int NBYTES = CW / BW;

   logic [BW-1:0] bytes [NBYTES];
   logic          lo_read;

   assign lo_read = rd_en && (rd_idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
         tmp_q <= '0;
      end else begin
         if (lo_read) tmp_q <= cap_q[CW-1:BW];
         if (evt)     cap_q <= cnt;
      end
   end

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         if (b == 0) begin : g_live
            assign bytes[b] = cap_q[BW-1:0];
         end else begin : g_held
            assign bytes[b] = tmp_q[(b-1)*BW +: BW];
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         for (int i = 0; i < NBYTES; i++) begin
            if (rd_idx == IDXW'(i)) rd_data = bytes[i];
         end
      end
   end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
   import tcap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   localparam int NBYTES     = CNT_W / BUS_W,
   localparam int IDXW       = idx_width(CNT_W / BUS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             trig_pin,
   input  logic             trig_cmp,
   input  logic             cfg_src_cmp,
   input  logic             cfg_rise,
   input  logic             cfg_filt_en,
   input  logic             irq_en,
   input  logic             flag_wr1,
   input  logic             irq_ack,
   input  logic             rd_en,
   input  logic [IDXW-1:0]  rd_idx,
   output logic [BUS_W-1:0] rd_data,
   output logic             cap_flag,
   output logic             irq
);
   generate
      if (CNT_W % BUS_W != 0) begin : g_err_div
         $error("CNT_W must be a multiple of BUS_W");
      end
      if (NBYTES < 2) begin : g_err_narrow
         $error("CNT_W must span at least two bus bytes");
      end
      if (SYNC_STAGES < 2) begin : g_err_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   tcap_cfg_t cfg;
   logic      src_raw;
   logic      src_sync;
   logic      lvl;
   logic      evt;
   logic [CNT_W-1:0]       cap_q;
   logic [CNT_W-BUS_W-1:0] tmp_q;

   assign cfg.src  = tcap_src_e'(cfg_src_cmp);
   assign cfg.pol  = tcap_edge_e'(cfg_rise);
   assign cfg.filt = cfg_filt_en;

   assign src_raw = (cfg.src == SRC_CMP) ? trig_cmp : trig_pin;

   tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_raw),
      .q     (src_sync)
   );

   tcap_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg.filt),
      .din   (src_sync),
      .lvl   (lvl)
   );

   tcap_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .pol   (cfg.pol),
      .evt   (evt)
   );

   tcap_store #(.CW(CNT_W), .BW(BUS_W), .IDXW(IDXW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .cnt     (cnt_val),
      .rd_en   (rd_en),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .cap_q   (cap_q),
      .tmp_q   (tmp_q)
   );

   // set has priority over any clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cap_flag <= 1'b0;
      else if (evt)                 cap_flag <= 1'b1;
      else if (flag_wr1 || irq_ack) cap_flag <= 1'b0;
   end

   assign irq = cap_flag & irq_en;
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
   parameter int CW   = 16,
   parameter int BW   = 8,
   parameter int IDXW = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            evt,
   input logic [CW-1:0]   cnt_val,
   input logic [CW-1:0]   cap_q,
   input logic [CW-BW-1:0] tmp_q,
   input logic            rd_en,
   input logic [IDXW-1:0] rd_idx,
   input logic            cap_flag,
   input logic            flag_wr1,
   input logic            irq_ack,
   input logic            irq_en,
   input logic            irq
);
   // R1
   cap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (cap_q == $past(cnt_val)));

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> cap_flag);

   // R6
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_flag) |-> $past(evt));

   // R7
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && (flag_wr1 || irq_ack)) |=> !cap_flag);

   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($rose(cap_flag) || $rose(irq_en)));

   // R9
   hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_idx == '0) |=> (tmp_q == $past(cap_q[CW-1:BW])));
endmodule

bind tcap_unit tcap_chk #(.CW(CNT_W), .BW(BUS_W), .IDXW(IDXW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt      (evt),
   .cnt_val  (cnt_val),
   .cap_q    (cap_q),
   .tmp_q    (tmp_q),
   .rd_en    (rd_en),
   .rd_idx   (rd_idx),
   .cap_flag (cap_flag),
   .flag_wr1 (flag_wr1),
   .irq_ack  (irq_ack),
   .irq_en   (irq_en),
   .irq      (irq)
);

// File: tb/tb_tcap_unit.sv
module tb_tcap_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_val = 16'h0;
   logic [15:0] cnt_jump = 16'h0;
   logic        trig_pin = 0, trig_cmp = 0;
   logic        cfg_src_cmp = 0, cfg_rise = 1, cfg_filt_en = 0;
   logic        irq_en = 0, flag_wr1 = 0, irq_ack = 0;
   logic        rd_en = 0;
   logic [0:0]  rd_idx = 1'b0;
   logic [7:0]  rd_data;
   logic        cap_flag, irq;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   always @(negedge clk) cnt_val <= cnt_val + 16'd1 + cnt_jump;

   tcap_unit dut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val),
      .trig_pin(trig_pin), .trig_cmp(trig_cmp),
      .cfg_src_cmp(cfg_src_cmp), .cfg_rise(cfg_rise), .cfg_filt_en(cfg_filt_en),
      .irq_en(irq_en), .flag_wr1(flag_wr1), .irq_ack(irq_ack),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
      .cap_flag(cap_flag), .irq(irq)
   );

   // behavioural reference: sample queue, run-length filter, edge, flag, bytes
   bit        sq[$];
   int        run;
   bit        last_s, acc, prev_l, m_flag;
   bit [15:0] m_cap;
   bit [7:0]  m_tmp;

   always @(posedge clk) begin
      if (!rst_n) begin
         sq = '{0, 0};
         run = 4; last_s = 0; acc = 0; prev_l = 0;
         m_flag = 0; m_cap = 0; m_tmp = 0;
      end else begin
         bit s_now, lv, ev, src;
         src   = cfg_src_cmp ? trig_cmp : trig_pin;
         s_now = sq[0];
         lv    = cfg_filt_en ? acc : s_now;
         ev    = cfg_rise ? (lv && !prev_l) : (!lv && prev_l);
         if (rd_en && rd_idx == 1'b0) m_tmp = m_cap[15:8];
         if (ev) m_cap = cnt_val;
         if (ev) m_flag = 1;
         else if (flag_wr1 || irq_ack) m_flag = 0;
         prev_l = lv;
         if (s_now == last_s) run++; else run = 1;
         last_s = s_now;
         if (!cfg_filt_en) acc = s_now;
         else if (run >= 4) acc = s_now;
         void'(sq.pop_front());
         sq.push_back(src);
      end
   end

   task automatic chk(string req, longint act, longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         bit [7:0] e_rd;
         e_rd = !rd_en ? 8'h0 : (rd_idx == 1'b0 ? m_cap[7:0] : m_tmp);
         chk("R9 rd_data vs model", rd_data, e_rd);
         chk("R6 cap_flag vs model", cap_flag, m_flag);
         chk("R8 irq vs model", irq, m_flag && irq_en);
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic wait_n(int n);
      repeat (n) step();
   endtask

   task automatic read16(output logic [15:0] v);
      rd_en = 1; rd_idx = 1'b0; #1 v[7:0] = rd_data;
      step();
      rd_idx = 1'b1; #1 v[15:8] = rd_data;
      step();
      rd_en = 0; rd_idx = 1'b0;
   endtask

   task automatic clr_flag();
      flag_wr1 = 1; step(); flag_wr1 = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [15:0] c, c2, v;
      logic [7:0]  lo;
      wait_n(5);
      rst_n = 1;
      step();
      // R10 reset state
      chk("R10 flag after reset", cap_flag, 0);
      chk("R10 irq after reset", irq, 0);
      read16(v);
      chk("R10 capture after reset", v, 16'h0);

      // R1 R4 unfiltered rising capture on pin
      step(); c = cnt_val; trig_pin = 1;
      wait_n(6);
      chk("R6 flag set", cap_flag, 1);
      chk("R8 irq masked", irq, 0);
      irq_en = 1; #1;
      chk("R8 irq enabled", irq, 1);
      read16(v);
      chk("R1 R4 captured value", v, c + 16'd2);

      // R7 write-one clear
      clr_flag(); #1;
      chk("R7 cleared by write one", cap_flag, 0);

      // R3 falling ignored while rising selected
      trig_pin = 0; wait_n(6);
      chk("R3 falling ignored", cap_flag, 0);
      cfg_rise = 0; trig_pin = 1; wait_n(6);
      chk("R3 rising ignored", cap_flag, 0);
      step(); c = cnt_val; trig_pin = 0; wait_n(6);
      chk("R3 falling captured flag", cap_flag, 1);
      read16(v);
      chk("R3 falling captured value", v, c + 16'd2);
      irq_ack = 1; step(); irq_ack = 0; #1;
      chk("R7 cleared by ack", cap_flag, 0);
      cfg_rise = 1; wait_n(2);

      // R2 source select
      trig_cmp = 1; wait_n(6);
      chk("R2 comparator unselected", cap_flag, 0);
      trig_cmp = 0; wait_n(4);
      cfg_src_cmp = 1; wait_n(4);
      step(); c = cnt_val; trig_cmp = 1; wait_n(6);
      chk("R2 comparator capture flag", cap_flag, 1);
      read16(v);
      chk("R2 comparator value", v, c + 16'd2);
      clr_flag();
      trig_pin = 1; wait_n(6);
      chk("R2 pin unselected", cap_flag, 0);
      trig_pin = 0; trig_cmp = 0; wait_n(6);
      cfg_src_cmp = 0; wait_n(4);
      clr_flag();

      // R5 filter
      cfg_filt_en = 1; wait_n(6);
      trig_pin = 1; wait_n(3); trig_pin = 0; wait_n(10);
      chk("R5 glitch rejected", cap_flag, 0);
      step(); c = cnt_val; trig_pin = 1; wait_n(5);
      chk("R5 not yet captured", cap_flag, 0);
      wait_n(4);
      chk("R5 filtered capture flag", cap_flag, 1);
      read16(v);
      chk("R5 filtered latency value", v, c + 16'd6);
      clr_flag();
      trig_pin = 0; wait_n(10);
      cfg_filt_en = 0; wait_n(4);
      clr_flag(); #1;
      chk("R7 flag clear before set-wins test", cap_flag, 0);

      // R6 set wins over clear on the same edge
      trig_pin = 1; step(); step();
      flag_wr1 = 1; step(); flag_wr1 = 0; #1;
      chk("R6 set beats clear", cap_flag, 1);
      clr_flag();
      trig_pin = 0; wait_n(6);

      // R9 coherent read across a new capture
      step(); c = cnt_val; trig_pin = 1; wait_n(6);
      clr_flag();
      rd_en = 1; rd_idx = 1'b0; #1 lo = rd_data;
      c2 = cnt_val; cnt_jump = 16'h3000; cfg_rise = 0; trig_pin = 0;
      step(); rd_en = 0; cnt_jump = 16'h0;
      wait_n(5);
      chk("R9 new capture flagged", cap_flag, 1);
      rd_en = 1; rd_idx = 1'b1; #1;
      chk("R9 held high byte", {rd_data, lo}, c + 16'd2);
      step(); rd_en = 0; rd_idx = 1'b0;
      read16(v);
      chk("R1 capture after jump", v, c2 + 16'h3002);
      cfg_rise = 1;
      wait_n(4);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule